// File: doc/BRIEF.md
# Gate Driver Fault Supervisor

This block gathers the supply and fault conditions of a two-switch gate-driver stage. It turns them into three control signals. The first is a global drive enable that lets the PWM path steer the upper and lower switches. The second is a forced-rectifier request that turns the upper switch off and the lower switch on, skipping the usual wait for the switch node to fall. The third is a supply-good output that can gate auxiliary circuits.

The analog comparators are represented by single-bit flags sampled on the block clock:
- **Lockout hysteresis:** the supply flags use two thresholds, one to enter lockout and one to leave it.
- **Over-voltage:** the request latches only after a filtered run of trip samples. It clears only when a separate release flag reports a level well below the trip point.
- **Over-temperature:** it also uses a trip flag and a release flag.

When more than one condition is active, they take priority in this order: shutdown, undervoltage lockout, over-temperature, over-voltage, normal operation.

Top module: `gd_fault_supervisor`

## Requirements
- R1: `supply_good` is high exactly when `shdn_n` is high and the block is out of undervoltage lockout.
- R2: While `shdn_n` is low, `drive_en`, `force_low_on` and `supply_good` are all low in the same cycle, whatever the fault state.
- R3: Lockout is entered on the clock edge after `uv_below_off` is seen high, and left on the edge after `uv_above_on` is seen high. With neither flag high, the lockout state holds.
- R4: After reset and during lockout, `drive_en` and `force_low_on` are both low.
- R5: The over-voltage state is entered only after `ov_above_trip` has been sampled high on OV_FILTER consecutive edges (default 16). A shorter run followed by a low sample has no effect.
- R6: In the over-voltage state, with no higher-priority condition, `force_low_on` is high and `drive_en` is low.
- R7: The over-voltage state persists until `ov_below_release` is sampled high, and it clears on that edge.
- R8: On the edge after `ot_trip` is sampled high, both `drive_en` and `force_low_on` go low. They stay low until `ot_release` is sampled high.
- R9: `drive_en` and `force_low_on` are never high together. Over-temperature overrides a latched over-voltage state, which reappears once the over-temperature state clears.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| shdn_n | input | 1 | Run request; low forces everything off |
| uv_below_off | input | 1 | Supply under the lower lockout threshold |
| uv_above_on | input | 1 | Supply over the upper lockout threshold |
| ov_above_trip | input | 1 | Sense above the over-voltage trip level |
| ov_below_release | input | 1 | Sense below the over-voltage release level |
| ot_trip | input | 1 | Die temperature above trip point |
| ot_release | input | 1 | Die temperature has dropped by the release margin |
| drive_en | output | 1 | PWM may control both switches |
| force_low_on | output | 1 | Force upper off, lower on, no dead-time wait |
| supply_good | output | 1 | Supply-good indication |

## Verification
The assertions check several properties on every cycle:
- the shutdown override;
- that `drive_en` and `force_low_on` are mutually exclusive;
- that the lockout state holds without a release flag;
- that a latched over-voltage state persists without a release flag;
- that an over-temperature trip drives everything low on the next edge;
- that the over-voltage state is only entered after a trip sample.

The exact length of the filter window needs the bench's directed scenarios, which hold the trip flag for one cycle short of the window and then for the full window. So do the lockout hysteresis across idle cycles and the return of the over-voltage request after an over-temperature release.

// File: rtl/gd_fault_supervisor.sv
module gd_fault_supervisor #(
  parameter int OV_FILTER = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic shdn_n,
  input  logic uv_below_off,
  input  logic uv_above_on,
  input  logic ov_above_trip,
  input  logic ov_below_release,
  input  logic ot_trip,
  input  logic ot_release,
  output logic drive_en,
  output logic force_low_on,
  output logic supply_good
);

  localparam int CW = (OV_FILTER > 2) ? $clog2(OV_FILTER) : 1;
  localparam logic [CW-1:0] CNT_LAST = CW'(OV_FILTER - 1);

  logic          lockout_q;
  logic          ot_q;
  logic          ov_q;
  logic [CW-1:0] ov_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      lockout_q <= 1'b1;
    else if (lockout_q && uv_above_on)
      lockout_q <= 1'b0;
    else if (!lockout_q && uv_below_off)
      lockout_q <= 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ot_q <= 1'b0;
    else if (ot_trip)
      ot_q <= 1'b1;
    else if (ot_release)
      ot_q <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ov_q   <= 1'b0;
      ov_cnt <= '0;
    end else if (ov_q) begin
      ov_cnt <= '0;
      if (ov_below_release)
        ov_q <= 1'b0;
    end else if (ov_above_trip) begin
      if (ov_cnt == CNT_LAST) begin
        ov_q   <= 1'b1;
        ov_cnt <= '0;
      end else begin
        ov_cnt <= ov_cnt + 1'b1;
      end
    end else begin
      ov_cnt <= '0;
    end
  end

  logic run_ok;
  assign run_ok       = shdn_n && !lockout_q && !ot_q;
  assign supply_good  = shdn_n && !lockout_q;
  assign drive_en     = run_ok && !ov_q;
  assign force_low_on = run_ok && ov_q;

endmodule

module gd_fault_supervisor_chk (
  input logic clk,
  input logic rst_n,
  input logic shdn_n,
  input logic uv_above_on,
  input logic ov_above_trip,
  input logic ov_below_release,
  input logic ot_trip,
  input logic drive_en,
  input logic force_low_on,
  input logic supply_good,
  input logic lockout_q,
  input logic ov_q
);

  assert_supply_good_R1: assert property (@(posedge clk) disable iff (!rst_n)
    supply_good |-> (shdn_n && !lockout_q));

  assert_shutdown_off_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !shdn_n |-> (!drive_en && !force_low_on && !supply_good));

  assert_lockout_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (lockout_q && !uv_above_on) |=> lockout_q);

  assert_lockout_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
    lockout_q |-> (!drive_en && !force_low_on));

  assert_ov_needs_trip_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ov_q) |-> $past(ov_above_trip));

  assert_ov_persist_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !ov_below_release) |=> ov_q);

  assert_ot_off_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ot_trip |=> (!drive_en && !force_low_on));

  assert_exclusive_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(drive_en && force_low_on));

endmodule

bind gd_fault_supervisor gd_fault_supervisor_chk u_chk (.*);

// File: tb/test_gd_fault_supervisor.sv
module test_gd_fault_supervisor;

  localparam int N = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic shdn_n = 1'b1;
  logic uv_below_off = 1'b0;
  logic uv_above_on = 1'b0;
  logic ov_above_trip = 1'b0;
  logic ov_below_release = 1'b0;
  logic ot_trip = 1'b0;
  logic ot_release = 1'b0;
  logic drive_en, force_low_on, supply_good;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  gd_fault_supervisor #(.OV_FILTER(N)) i_gd_fault_supervisor (
    .clk(clk), .rst_n(rst_n), .shdn_n(shdn_n),
    .uv_below_off(uv_below_off), .uv_above_on(uv_above_on),
    .ov_above_trip(ov_above_trip), .ov_below_release(ov_below_release),
    .ot_trip(ot_trip), .ot_release(ot_release),
    .drive_en(drive_en), .force_low_on(force_low_on), .supply_good(supply_good)
  );

  task automatic step(int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic de, logic fl, logic sg);
    #0.5;
    checks++;
    if (drive_en !== de || force_low_on !== fl || supply_good !== sg) begin
      errors++;
      $display("FAIL %s: got de=%b fl=%b sg=%b expected de=%b fl=%b sg=%b",
               req, drive_en, force_low_on, supply_good, de, fl, sg);
    end
  endtask

  task automatic t_reset();
    step(2);
    chk("R4 reset", 0, 0, 0);
    rst_n = 1'b1;
    step(3);
    chk("R4 lockout after reset", 0, 0, 0);
  endtask

  task automatic t_lockout();
    uv_above_on = 1'b1;
    step(1);
    chk("R3 leave lockout / R1", 1, 0, 1);
    uv_above_on = 1'b0;
    step(4);
    chk("R3 hold out of lockout", 1, 0, 1);
    uv_below_off = 1'b1;
    step(1);
    chk("R3 enter lockout / R4", 0, 0, 0);
    uv_below_off = 1'b0;
    step(4);
    chk("R3 hold in lockout", 0, 0, 0);
    uv_above_on = 1'b1;
    step(1);
    uv_above_on = 1'b0;
    chk("R1 supply good again", 1, 0, 1);
  endtask

  task automatic t_shutdown();
    shdn_n = 1'b0;
    chk("R2 shutdown same cycle", 0, 0, 0);
    step(2);
    chk("R2 shutdown held", 0, 0, 0);
    shdn_n = 1'b1;
    chk("R1 shutdown released", 1, 0, 1);
  endtask

  task automatic t_ov();
    ov_above_trip = 1'b1;
    step(N - 1);
    ov_above_trip = 1'b0;
    step(3);
    chk("R5 short run ignored", 1, 0, 1);
    ov_above_trip = 1'b1;
    step(N - 1);
    chk("R5 not yet latched", 1, 0, 1);
    step(1);
    chk("R6 latched after full window", 0, 1, 1);
    ov_above_trip = 1'b0;
    step(5);
    chk("R7 persists without release", 0, 1, 1);
    ov_below_release = 1'b1;
    step(1);
    ov_below_release = 1'b0;
    chk("R7 release clears", 1, 0, 1);
  endtask

  task automatic latch_ov();
    ov_above_trip = 1'b1;
    step(N);
    ov_above_trip = 1'b0;
  endtask

  task automatic t_ot();
    ot_trip = 1'b1;
    step(1);
    ot_trip = 1'b0;
    chk("R8 trip turns off", 0, 0, 1);
    step(4);
    chk("R8 held until release", 0, 0, 1);
    ot_release = 1'b1;
    step(1);
    ot_release = 1'b0;
    chk("R8 release restores", 1, 0, 1);
    latch_ov();
    chk("R6 latched", 0, 1, 1);
    ot_trip = 1'b1;
    step(1);
    ot_trip = 1'b0;
    chk("R9 ot overrides ov", 0, 0, 1);
    ot_release = 1'b1;
    step(1);
    ot_release = 1'b0;
    chk("R9 ov returns after ot", 0, 1, 1);
    shdn_n = 1'b0;
    chk("R2 shutdown overrides ov", 0, 0, 0);
    shdn_n = 1'b1;
    uv_below_off = 1'b1;
    step(1);
    uv_below_off = 1'b0;
    chk("R4 lockout overrides ov", 0, 0, 0);
    uv_above_on = 1'b1;
    step(1);
    uv_above_on = 1'b0;
    chk("R9 ov after lockout", 0, 1, 1);
    ov_below_release = 1'b1;
    step(1);
    ov_below_release = 1'b0;
    chk("R7 final release", 1, 0, 1);
  endtask

  initial begin
    #1;
    t_reset();
    t_lockout();
    t_shutdown();
    t_ov();
    t_ot();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule